// File: doc/BRIEF.md
# Receive Packet Framing Handler

This block sits behind a sync-word detector. After a sync-found strobe it takes byte-aligned received data and splits it into packets. It supports two framing modes. In variable-length mode a leading length byte gives the packet size. In fixed-length mode the size comes from configuration. Accepted bytes go to a downstream byte FIFO write port.

The handler can optionally filter on a device address and verify an appended CRC-16. It can also append two status bytes: an RSSI byte, and a byte that joins the CRC result with a link-quality value. A one-cycle packet-done pulse ends each complete packet. An address mismatch gives a one-cycle reject pulse and drops the rest of the packet.

A single state machine drives the flow. Its states are:
- ST_IDLE: waiting for a sync.
- ST_LEN: length byte.
- ST_ADDR: address byte.
- ST_BODY: remaining packet bytes.
- ST_CRC_HI and ST_CRC_LO: appended CRC.
- ST_STAT_A and ST_STAT_B: status bytes.
- ST_DONE: done pulse.

Its transitions are:
- Sync: any state to ST_LEN, ST_ADDR or ST_BODY.
- Length accept: ST_LEN to ST_ADDR or ST_BODY.
- Length abort: ST_LEN to ST_IDLE.
- Address reject: ST_ADDR to ST_IDLE.
- Body end: to ST_CRC_HI, ST_STAT_A or ST_DONE.
- CRC end: ST_CRC_LO to ST_STAT_A or ST_DONE.
- Status sequence: ST_STAT_A to ST_STAT_B to ST_DONE.
- Finish: ST_DONE to ST_IDLE.

Top module: `rx_frame_handler`

## Requirements
- R1: While reset is asserted and after its release, with no stimulus, `fifo_wr`, `pkt_done`, `addr_rej` and `crc_ok` are 0.
- R2: A `sync_found` pulse starts a new packet from any state and abandons any packet in progress. A `byte_vld` in the same cycle as `sync_found` is ignored.
- R3: With `cfg_var_len`=1, the first byte after sync is the length N. It is written to the FIFO, and then exactly N more bytes are taken as packet bytes. Bytes that arrive after a packet has ended and before the next sync are ignored. Each accepted byte appears on `fifo_wr`/`fifo_dat` one clock after the edge where it was accepted.
- R4: With `cfg_var_len`=0, exactly `cfg_fix_len` packet bytes are taken and no length byte is interpreted. A `cfg_fix_len` of 0 accepts nothing.
- R5: In variable mode, a length byte of 0 or a value above `cfg_max_len` aborts the packet. Nothing is written and there is no `pkt_done`. A length equal to `cfg_max_len` is accepted.
- R6: With `cfg_addr_chk`=1, the first packet byte is the address, and it counts toward the length. If it equals `cfg_dev_addr` it is written and reception continues. If not, `addr_rej` pulses for one cycle and no further byte or `pkt_done` follows.
- R7: With `cfg_crc_chk`=1, two CRC bytes (high byte first) follow the packet bytes and are not written to the FIFO. The CRC is CRC-16, polynomial 0x8005, initial value 0xFFFF, computed MSB-first over the length, address and payload bytes. `crc_ok` is 1 only when the received CRC equals the computed one. With the check disabled, `crc_ok` is 1 for each completed packet.
- R8: With `cfg_stat_app`=1, two bytes are written after the packet bytes: first `rssi_in`, then {`crc_ok` in bit 7, `lqi_in` in bits 6:0}.
- R9: `pkt_done` pulses for one cycle, after the last FIFO write of the packet (or after the last CRC byte when there are no status bytes). At that point `crc_ok` holds the packet result. `crc_ok` keeps this value until the next `sync_found`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_found | input | 1 | Sync word detected; next byte is the first of a packet |
| byte_vld | input | 1 | Received byte strobe |
| byte_dat | input | DW | Received byte |
| cfg_var_len | input | 1 | 1: variable length with length byte, 0: fixed length |
| cfg_fix_len | input | DW | Packet length in fixed mode |
| cfg_max_len | input | DW | Largest accepted length byte in variable mode |
| cfg_dev_addr | input | DW | Device address for filtering |
| cfg_addr_chk | input | 1 | Enable address filtering |
| cfg_crc_chk | input | 1 | Enable CRC verification |
| cfg_stat_app | input | 1 | Enable appended status bytes |
| rssi_in | input | DW | Signal strength, two's complement |
| lqi_in | input | DW-1 | Link quality value |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_dat | output | DW | FIFO write data |
| pkt_done | output | 1 | One-cycle end-of-packet pulse |
| crc_ok | output | 1 | CRC result of the last packet |
| addr_rej | output | 1 | One-cycle address-mismatch pulse |

## Verification
The hardest situation to reach from the ports is a sync arriving in the middle of a packet. In the same run, a byte strobe sits on that very sync cycle and the next packet then has to frame cleanly. The stimulus starts a variable-length packet and feeds part of its body. It then raises sync together with a byte strobe, and follows at once with a full packet that uses address, CRC and status. The scoreboard expects only the partial writes of the first packet and the complete second packet. Length boundaries (zero, maximum, one above maximum), a corrupted CRC and stray bytes after packet end are also driven, and each must produce exactly the predicted FIFO traffic.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LEN,
        ST_ADDR,
        ST_BODY,
        ST_CRC_HI,
        ST_CRC_LO,
        ST_STAT_A,
        ST_STAT_B,
        ST_DONE
    } rxf_state_e;
endpackage

// File: rtl/rxf_crc16.sv
module rxf_crc16 #(
    parameter int          DW   = 8,
    parameter int          CW   = 16,
    parameter logic [CW-1:0] POLY = 16'h8005,
    parameter logic [CW-1:0] INIT = 16'hFFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          upd,
    input  logic [DW-1:0] din,
    output logic [CW-1:0] crc
);
    logic [CW-1:0] crc_q;
    logic [CW-1:0] crc_nx;

    // bitwise MSB-first update over one byte
    always_comb begin
        crc_nx = crc_q;
        for (int i = DW - 1; i >= 0; i--) begin
            if (crc_nx[CW-1] ^ din[i]) begin
                crc_nx = {crc_nx[CW-2:0], 1'b0} ^ POLY;
            end else begin
                crc_nx = {crc_nx[CW-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= INIT;
        end else if (init) begin
            crc_q <= INIT;
        end else if (upd) begin
            crc_q <= crc_nx;
        end
    end

    assign crc = crc_q;
endmodule

// File: rtl/rxf_len_ctr.sv
module rxf_len_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_val;
        end else if (dec && rem_q != '0) begin
            rem_q <= rem_q - ONE;
        end
    end

    assign last = (rem_q == ONE);
endmodule

// File: rtl/rxf_stat_fmt.sv
module rxf_stat_fmt #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] rssi,
    input  logic [DW-2:0] lqi,
    input  logic          crc_good,
    output logic [DW-1:0] stat_a,
    output logic [DW-1:0] stat_b
);
    assign stat_a = rssi;
    assign stat_b = {crc_good, lqi};
endmodule

// File: rtl/rx_frame_handler.sv
module rx_frame_handler
    import rxf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_found,
    input  logic          byte_vld,
    input  logic [DW-1:0] byte_dat,
    input  logic          cfg_var_len,
    input  logic [DW-1:0] cfg_fix_len,
    input  logic [DW-1:0] cfg_max_len,
    input  logic [DW-1:0] cfg_dev_addr,
    input  logic          cfg_addr_chk,
    input  logic          cfg_crc_chk,
    input  logic          cfg_stat_app,
    input  logic [DW-1:0] rssi_in,
    input  logic [DW-2:0] lqi_in,
    output logic          fifo_wr,
    output logic [DW-1:0] fifo_dat,
    output logic          pkt_done,
    output logic          crc_ok,
    output logic          addr_rej
);
    localparam int CW = 2 * DW;

    rxf_state_e state_q, state_nx, tail_st, first_st;

    logic          wr_nx, done_nx, rej_nx, crcok_nx;
    logic [DW-1:0] dat_nx;
    logic          crc_init, crc_upd;
    logic [CW-1:0] crc_val;
    logic          cnt_load, cnt_dec, cnt_last;
    logic [DW-1:0] cnt_val;
    logic          hi_cap;
    logic [DW-1:0] crc_hi_q;
    logic [DW-1:0] stat_a, stat_b;

    rxf_crc16 #(.DW(DW), .CW(CW)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .upd   (crc_upd),
        .din   (byte_dat),
        .crc   (crc_val)
    );

    rxf_len_ctr #(.CNT_W(DW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    rxf_stat_fmt #(.DW(DW)) u_stat (
        .rssi     (rssi_in),
        .lqi      (lqi_in),
        .crc_good (crc_ok),
        .stat_a   (stat_a),
        .stat_b   (stat_b)
    );

    // state after the packet bytes, and first state of the packet body
    always_comb begin
        if (cfg_crc_chk) begin
            tail_st = ST_CRC_HI;
        end else if (cfg_stat_app) begin
            tail_st = ST_STAT_A;
        end else begin
            tail_st = ST_DONE;
        end
        first_st = cfg_addr_chk ? ST_ADDR : ST_BODY;
    end

    // next-state and output decisions
    always_comb begin
        state_nx = state_q;
        wr_nx    = 1'b0;
        dat_nx   = '0;
        done_nx  = 1'b0;
        rej_nx   = 1'b0;
        crcok_nx = crc_ok;
        crc_init = 1'b0;
        crc_upd  = 1'b0;
        cnt_load = 1'b0;
        cnt_val  = cfg_fix_len;
        cnt_dec  = 1'b0;
        hi_cap   = 1'b0;
        if (sync_found) begin
            crc_init = 1'b1;
            crcok_nx = 1'b0;
            if (cfg_var_len) begin
                state_nx = ST_LEN;
            end else if (cfg_fix_len == '0) begin
                state_nx = ST_IDLE;
            end else begin
                cnt_load = 1'b1;
                state_nx = first_st;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_nx = ST_IDLE;
                end
                ST_LEN: begin
                    if (byte_vld) begin
                        if (byte_dat == '0 || byte_dat > cfg_max_len) begin
                            state_nx = ST_IDLE;
                        end else begin
                            wr_nx    = 1'b1;
                            dat_nx   = byte_dat;
                            crc_upd  = 1'b1;
                            cnt_load = 1'b1;
                            cnt_val  = byte_dat;
                            state_nx = first_st;
                        end
                    end
                end
                ST_ADDR, ST_BODY: begin
                    if (byte_vld) begin
                        if (state_q == ST_ADDR && byte_dat != cfg_dev_addr) begin
                            rej_nx   = 1'b1;
                            state_nx = ST_IDLE;
                        end else begin
                            wr_nx   = 1'b1;
                            dat_nx  = byte_dat;
                            crc_upd = 1'b1;
                            cnt_dec = 1'b1;
                            if (cnt_last) begin
                                state_nx = tail_st;
                                if (!cfg_crc_chk) begin
                                    crcok_nx = 1'b1;
                                end
                            end else begin
                                state_nx = ST_BODY;
                            end
                        end
                    end
                end
                ST_CRC_HI: begin
                    if (byte_vld) begin
                        hi_cap   = 1'b1;
                        state_nx = ST_CRC_LO;
                    end
                end
                ST_CRC_LO: begin
                    if (byte_vld) begin
                        crcok_nx = ({crc_hi_q, byte_dat} == crc_val);
                        state_nx = cfg_stat_app ? ST_STAT_A : ST_DONE;
                    end
                end
                ST_STAT_A: begin
                    wr_nx    = 1'b1;
                    dat_nx   = stat_a;
                    state_nx = ST_STAT_B;
                end
                ST_STAT_B: begin
                    wr_nx    = 1'b1;
                    dat_nx   = stat_b;
                    state_nx = ST_DONE;
                end
                ST_DONE: begin
                    done_nx  = 1'b1;
                    state_nx = ST_IDLE;
                end
                default: begin
                    state_nx = ST_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            crc_hi_q <= '0;
        end else begin
            state_q <= state_nx;
            if (hi_cap) begin
                crc_hi_q <= byte_dat;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_wr  <= 1'b0;
            fifo_dat <= '0;
            pkt_done <= 1'b0;
            addr_rej <= 1'b0;
            crc_ok   <= 1'b0;
        end else begin
            fifo_wr  <= wr_nx;
            fifo_dat <= dat_nx;
            pkt_done <= done_nx;
            addr_rej <= rej_nx;
            crc_ok   <= crcok_nx;
        end
    end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
    input logic clk,
    input logic rst_n,
    input logic sync_found,
    input logic fifo_wr,
    input logic pkt_done,
    input logic crc_ok,
    input logic addr_rej
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done); // R9
    AST_DONE_NOT_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_done && fifo_wr)); // R9
    AST_CRCOK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sync_found |=> !crc_ok); // R9
    AST_CRCOK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_ok && !sync_found) |=> crc_ok); // R9
    AST_REJ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_rej |=> !addr_rej); // R6
    AST_NO_WR_AFTER_REJ: assert property (@(posedge clk) disable iff (!rst_n)
        addr_rej |=> (!fifo_wr && !pkt_done)); // R6
    AST_REJ_NOT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_rej && (pkt_done || fifo_wr))); // R6
endmodule

bind rx_frame_handler rxf_checker i_rxf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_found (sync_found),
    .fifo_wr    (fifo_wr),
    .pkt_done   (pkt_done),
    .crc_ok     (crc_ok),
    .addr_rej   (addr_rej)
);

// File: tb/test_rx_frame_handler.sv
module test_rx_frame_handler;
    localparam int DW = 8;
    localparam logic [1:0] K_WR = 2'd1, K_DONE = 2'd2, K_REJ = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_found = 1'b0;
    logic          byte_vld = 1'b0;
    logic [DW-1:0] byte_dat = '0;
    logic          cfg_var_len = 1'b1;
    logic [DW-1:0] cfg_fix_len = '0;
    logic [DW-1:0] cfg_max_len = 8'd20;
    logic [DW-1:0] cfg_dev_addr = 8'h5A;
    logic          cfg_addr_chk = 1'b0;
    logic          cfg_crc_chk = 1'b0;
    logic          cfg_stat_app = 1'b0;
    logic [DW-1:0] rssi_in = 8'hB5;
    logic [DW-2:0] lqi_in = 7'h2A;
    logic          fifo_wr, pkt_done, crc_ok, addr_rej;
    logic [DW-1:0] fifo_dat;

    int n_chk = 0;
    int n_bad = 0;
    logic [9:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    rx_frame_handler #(.DW(DW)) i_rx_frame_handler (
        .clk(clk), .rst_n(rst_n), .sync_found(sync_found), .byte_vld(byte_vld),
        .byte_dat(byte_dat), .cfg_var_len(cfg_var_len), .cfg_fix_len(cfg_fix_len),
        .cfg_max_len(cfg_max_len), .cfg_dev_addr(cfg_dev_addr),
        .cfg_addr_chk(cfg_addr_chk), .cfg_crc_chk(cfg_crc_chk),
        .cfg_stat_app(cfg_stat_app), .rssi_in(rssi_in), .lqi_in(lqi_in),
        .fifo_wr(fifo_wr), .fifo_dat(fifo_dat), .pkt_done(pkt_done),
        .crc_ok(crc_ok), .addr_rej(addr_rej)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[15] ^ b[i];
            r = r << 1;
            if (fb) r = r ^ 16'h8005;
        end
        return r;
    endfunction

    task automatic push(input logic [1:0] k, input logic [7:0] d, input string tag);
        exp_q.push_back({k, d});
        tag_q.push_back(tag);
    endtask

    // monitor: compare every output event with the scoreboard head
    task automatic take(input logic [9:0] got);
        if (exp_q.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL unexpected event: actual %h expected none", got);
        end else begin
            logic [9:0] e = exp_q.pop_front();
            string t = tag_q.pop_front();
            check(t, 16'(got), 16'(e));
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (fifo_wr)  take({K_WR, fifo_dat});
            if (pkt_done) take({K_DONE, 7'd0, crc_ok});
            if (addr_rej) take({K_REJ, 8'd0});
        end
    end

    task automatic send(input logic [7:0] b);
        byte_vld = 1'b1; byte_dat = b;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic sync_pulse;
        sync_found = 1'b1;
        @(negedge clk);
        sync_found = 1'b0;
    endtask

    // n: length (variable) or ignored (fixed uses cfg_fix_len)
    task automatic run_pkt(input int n, input logic [7:0] addr, input bit good,
                           input int seed, input string tag);
        logic [15:0] c = 16'hFFFF;
        int len = cfg_var_len ? n : int'(cfg_fix_len);
        bit ok = 1'b1;
        sync_pulse();
        if (cfg_var_len) begin
            if (n == 0 || n > int'(cfg_max_len)) begin
                send(8'(n)); send(8'h11); send(8'h22);
                repeat (4) @(negedge clk);
                return;
            end
            push(K_WR, 8'(n), tag);
            c = crc_step(c, 8'(n));
            send(8'(n));
        end else if (len == 0) begin
            send(8'h33); send(8'h44);
            repeat (4) @(negedge clk);
            return;
        end
        for (int i = 0; i < len; i++) begin
            logic [7:0] b = (i == 0 && cfg_addr_chk) ? addr : 8'(seed * 7 + i * 13 + 1);
            if (i == 0 && cfg_addr_chk && addr != cfg_dev_addr) begin
                push(K_REJ, 8'd0, tag);
                send(b); send(8'h66); send(8'h77);
                repeat (4) @(negedge clk);
                return;
            end
            push(K_WR, b, tag);
            c = crc_step(c, b);
            send(b);
        end
        if (cfg_crc_chk) begin
            ok = good;
            send(c[15:8]);
            send(good ? c[7:0] : c[7:0] ^ 8'h01);
        end
        if (cfg_stat_app) begin
            push(K_WR, rssi_in, "R8 rssi byte");
            push(K_WR, {ok, lqi_in}, "R8 crc/lqi byte");
        end
        push(K_DONE, {7'd0, ok}, "R9 done/crc_ok");
        repeat (5) @(negedge clk);
        // stray bytes after packet end must be ignored (R3)
        send(8'hE1); send(8'hE2);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset fifo_wr", 16'(fifo_wr), 16'd0);
        check("R1 reset pkt_done", 16'(pkt_done), 16'd0);
        check("R1 reset crc_ok", 16'(crc_ok), 16'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle addr_rej", 16'(addr_rej), 16'd0);
        check("R1 idle fifo_wr", 16'(fifo_wr), 16'd0);

        // R3 plain variable-length
        run_pkt(4, 8'h00, 1'b1, 1, "R3 var plain");
        // R7 crc disabled gives crc_ok=1, held until sync (R9)
        check("R9 crc_ok held", 16'(crc_ok), 16'd1);
        sync_pulse();
        check("R9 crc_ok cleared by sync", 16'(crc_ok), 16'd0);
        repeat (3) @(negedge clk);

        // R6 R7 R8 full-featured, good crc
        cfg_addr_chk = 1'b1; cfg_crc_chk = 1'b1; cfg_stat_app = 1'b1;
        run_pkt(6, 8'h5A, 1'b1, 2, "R6 R7 var addr crc good");
        // R7 bad crc
        run_pkt(5, 8'h5A, 1'b0, 3, "R7 var crc bad");
        check("R9 crc_ok held low after bad crc", 16'(crc_ok), 16'd0);
        // R6 address mismatch
        run_pkt(5, 8'hA5, 1'b1, 4, "R6 addr mismatch");
        // R6 length 1: address only
        run_pkt(1, 8'h5A, 1'b1, 5, "R6 addr only packet");

        // R5 aborts and boundary
        cfg_addr_chk = 1'b0;
        run_pkt(0, 8'h00, 1'b1, 6, "R5 zero length");
        run_pkt(21, 8'h00, 1'b1, 7, "R5 over max");
        run_pkt(20, 8'h00, 1'b1, 8, "R5 at max");

        // R2 restart mid-packet, byte on the sync cycle ignored
        sync_pulse();
        push(K_WR, 8'd5, "R2 partial len");
        send(8'd5);
        push(K_WR, 8'h91, "R2 partial body");
        send(8'h91);
        cfg_addr_chk = 1'b1;
        sync_found = 1'b1; byte_vld = 1'b1; byte_dat = 8'hC3;
        @(negedge clk);
        sync_found = 1'b0; byte_vld = 1'b0;
        begin
            logic [15:0] c = crc_step(16'hFFFF, 8'd3);
            push(K_WR, 8'd3, "R2 restart len");
            send(8'd3);
            push(K_WR, 8'h5A, "R2 restart addr");
            c = crc_step(c, 8'h5A); send(8'h5A);
            push(K_WR, 8'h10, "R2 restart body");
            c = crc_step(c, 8'h10); send(8'h10);
            push(K_WR, 8'h20, "R2 restart body");
            c = crc_step(c, 8'h20); send(8'h20);
            send(c[15:8]); send(c[7:0]);
            push(K_WR, rssi_in, "R2 R8 rssi");
            push(K_WR, {1'b1, lqi_in}, "R2 R8 lqi");
            push(K_DONE, 8'd1, "R2 R9 done");
            repeat (6) @(negedge clk);
        end

        // R4 fixed length with addr/crc/status, different status values
        cfg_var_len = 1'b0; cfg_fix_len = 8'd5;
        rssi_in = 8'h1C; lqi_in = 7'h55;
        run_pkt(0, 8'h5A, 1'b1, 9, "R4 fixed full");
        cfg_addr_chk = 1'b0; cfg_crc_chk = 1'b0; cfg_stat_app = 1'b0;
        cfg_fix_len = 8'd3;
        run_pkt(0, 8'h00, 1'b1, 10, "R4 fixed plain");
        cfg_fix_len = 8'd0;
        run_pkt(0, 8'h00, 1'b1, 11, "R4 fixed zero");

        repeat (10) @(negedge clk);
        check("R3 scoreboard drained", 16'(exp_q.size()), 16'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule